// File: doc/BRIEF.md
# Four-Channel Input Capture Timer

This block is an up-counting timer with a shared prescaler and four input capture channels. It is set up through a small synchronous register bus. The count source is either an internal tick-enable input or the rising edges of an external clock pin. The counter wraps to zero after it reaches a programmable reload value, and each wrap raises an update flag. Each capture channel watches its own pin for a chosen edge: rising, falling or both. On that edge the channel stores the current counter value and sets a capture flag. If a second capture arrives while that flag is still set, the channel also sets an overcapture flag, so software can tell that a sample was lost.

Flags are cleared by writing zero to them. A single interrupt line is the OR of each update or capture flag gated by its enable bit. All pin inputs pass through a two-flop synchronizer before edge detection.

Top module: `capture_timer`

Register addresses (word index on `bus_addr`):

| Address | Register | Access |
|---|---|---|
| 0 | CTRL | read/write |
| 1 | STAT | read, write-zero-to-clear |
| 2 | IEN | read/write |
| 3 | PSC | read/write |
| 4 | RELOAD | read/write |
| 5 | COUNT | read only |
| 6 | CAPEN | read/write |
| 7, 8 | mode registers | read/write |
| 9 to 12 | capture values of channels 0 to 3 | read only |

## Requirements
- R1: The counter advances once every PSC+1 qualified source ticks, so PSC (address 3) equal to 0 means one step per tick. The active division ratio is reloaded from PSC only on an update-generation write or on a counter wrap.
- R2: The counter counts up to RELOAD (address 4). On its next step it returns to 0 and sets the update flag (STAT bit 0).
- R3: Writing 1 to CTRL bit 1 (address 0) clears the counter and the prescaler phase, and loads the active ratio from PSC. The bit reads back as 0, and this write does not set the update flag.
- R4: While the run bit (CTRL bit 0) is 0, the counter holds its value and no channel takes a capture.
- R5: CTRL bits 3:2 select the count source. 0 counts cycles with `tick` high. 1 counts synchronized rising edges of `ext_clk`. 2 and 3 count nothing.
- R6: Channel c is set up by CAPEN (address 6) bits [4c+3:4c]. Bit 4c enables the channel. With bit 4c+1 as polarity P and bit 4c+3 as complementary polarity N: P=0 captures rising edges, P=1 with N=0 captures falling edges, and P=1 with N=1 captures both edges. A disabled channel never captures.
- R7: A capture on channel c loads capture register 9+c with the counter value held in the cycle the synchronized edge is detected, and sets the capture flag at STAT bit 1+c.
- R8: A capture on a channel whose capture flag is still set also sets that channel's overcapture flag at STAT bit 5+c. The capture register takes the newer value.
- R9: Writing STAT clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A flag that is set in the same cycle stays set.
- R10: `irq` is high exactly when some flag in STAT bits 4:0 is set together with the IEN bit at the same position. Overcapture flags never drive `irq`.
- R11: The two mode registers (addresses 7 and 8) store 16-bit values and read them back. Each holds two 8-bit per-channel fields: the first register holds channels 0 and 1, the second holds channels 2 and 3, with the lower channel in bits 7:0.
- R12: After reset, COUNT is 0, RELOAD is all ones, PSC, CTRL, IEN and STAT are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Internal count tick enable |
| ext_clk | input | 1 | External count clock, asynchronous |
| cap_in | input | 4 | Capture pins, one per channel, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_wr`, `bus_addr` and `bus_wdata` are driven synchronously and are held stable around the clock edge. They also assume that the pin inputs change at most once per clock. The synchronizer then gives each edge a single-cycle detect pulse.

The stimulus changes every input on the falling clock edge. Pin pulses last at least three cycles, so both edges of each pulse pass through the synchronizer as separate detections. The bench compares against a behavioural model on every cycle.

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int DW    = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ext_clk,
  input  logic [3:0]    cap_in,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int NCH = 4;
  localparam int NSY = NCH + 1;
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_STAT  = AW'(1);
  localparam logic [AW-1:0] A_IEN   = AW'(2);
  localparam logic [AW-1:0] A_PSC   = AW'(3);
  localparam logic [AW-1:0] A_RLD   = AW'(4);
  localparam logic [AW-1:0] A_CNT   = AW'(5);
  localparam logic [AW-1:0] A_CAPEN = AW'(6);
  localparam logic [AW-1:0] A_MODEA = AW'(7);
  localparam logic [AW-1:0] A_MODEB = AW'(8);
  localparam logic [AW-1:0] A_CAP0  = AW'(9);

  logic [NSY-1:0] sy1, sy2, sy3;
  logic [NSY-1:0] rise, fall;
  logic           run;
  logic [1:0]     cmode;
  logic [NCH:0]   ien;
  logic [PSC_W-1:0] psc_reg, pact, pph;
  logic [CNT_W-1:0] rld, cnt;
  logic [4*NCH-1:0] capen;
  logic [DW-1:0]  mode_a, mode_b;
  logic           uf;
  logic [NCH-1:0] capf, ovf, hit;
  logic [NCH*CNT_W-1:0] capflat;
  logic           we_ctrl, we_stat, ug, src, step, pdone, wrap;
  logic           keep_uf;
  logic [NCH-1:0] keep_cf, keep_of;
  logic [AW-1:0]  cap_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= {ext_clk, cap_in};
      sy2 <= sy1;
      sy3 <= sy2;
    end

  assign rise    = sy2 & ~sy3;
  assign fall    = ~sy2 & sy3;
  assign we_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign we_stat = bus_wr && (bus_addr == A_STAT);
  assign ug      = we_ctrl && bus_wdata[1];

  always_comb
    case (cmode)
      2'd0:    src = tick;
      2'd1:    src = rise[NCH];
      default: src = 1'b0;
    endcase

  assign step  = run && src && !ug;
  assign pdone = step && (pph == pact);
  assign wrap  = pdone && (cnt == rld);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; pph <= '0; pact <= '0;
    end else if (ug) begin
      cnt <= '0; pph <= '0; pact <= psc_reg;
    end else if (step) begin
      pph <= pdone ? '0 : pph + 1'b1;
      if (pdone) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) pact <= psc_reg;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= 1'b0; cmode <= '0; ien <= '0; psc_reg <= '0; rld <= '1;
      capen <= '0; mode_a <= '0; mode_b <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  begin run <= bus_wdata[0]; cmode <= bus_wdata[3:2]; end
        A_IEN:   ien <= bus_wdata[NCH:0];
        A_PSC:   psc_reg <= bus_wdata[PSC_W-1:0];
        A_RLD:   rld <= bus_wdata[CNT_W-1:0];
        A_CAPEN: capen <= bus_wdata[4*NCH-1:0];
        A_MODEA: mode_a <= bus_wdata;
        A_MODEB: mode_b <= bus_wdata;
        default: ;
      endcase
    end

  assign keep_uf = we_stat ? bus_wdata[0] : 1'b1;
  assign keep_cf = we_stat ? bus_wdata[NCH:1] : '1;
  assign keep_of = we_stat ? bus_wdata[2*NCH:NCH+1] : '1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      uf <= 1'b0; capf <= '0; ovf <= '0;
    end else begin
      uf   <= (uf & keep_uf) | wrap;
      capf <= (capf & keep_cf) | hit;
      ovf  <= (ovf & keep_of) | (hit & capf & keep_cf);
    end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CNT_W-1:0] val;
    logic en, pol, npol;
    assign en   = capen[4*c];
    assign pol  = capen[4*c+1];
    assign npol = capen[4*c+3];
    assign hit[c] = run && en && ((rise[c] && (!pol || npol)) || (fall[c] && pol));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) val <= '0;
      else if (hit[c]) val <= cnt;

    assign capflat[c*CNT_W +: CNT_W] = val;

    p_capture_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit[c] |=> (val == $past(cnt)));
    p_ovc_needs_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[c]) |-> $past(capf[c]));
  end

  assign irq     = |({capf, uf} & ien);
  assign cap_idx = bus_addr - A_CAP0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'({cmode, 1'b0, run});
      A_STAT:  bus_rdata = DW'({ovf, capf, uf});
      A_IEN:   bus_rdata = DW'(ien);
      A_PSC:   bus_rdata = DW'(psc_reg);
      A_RLD:   bus_rdata = DW'(rld);
      A_CNT:   bus_rdata = DW'(cnt);
      A_CAPEN: bus_rdata = DW'(capen);
      A_MODEA: bus_rdata = mode_a;
      A_MODEB: bus_rdata = mode_b;
      default:
        if (bus_addr >= A_CAP0 && bus_addr < A_CAP0 + AW'(NCH))
          bus_rdata = DW'(capflat[cap_idx*CNT_W +: CNT_W]);
    endcase
  end

  p_hold_when_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ug) |=> $stable(cnt));
  p_ug_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (cnt == '0 && pph == '0));
  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0 && uf));
endmodule

// File: tb/capture_timer_bench.sv
module capture_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ext_clk = 1'b0;
  logic [3:0]  cap_in = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  wire  [15:0] bus_rdata;
  wire         irq;

  always #4 clk = ~clk;

  capture_timer u_capture_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_clk(ext_clk), .cap_in(cap_in),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  int n_chk = 0, n_fail = 0;

  bit m_run, m_uf;
  int m_mode, m_psc, m_pact, m_ph, m_arr, m_cnt;
  bit [4:0]  m_ien, q1, q2, q3, rr, ff;
  bit [3:0]  m_cf, m_of, hits;
  bit [15:0] m_capen, m_ma, m_mb;
  int m_cap [4];
  bit ug_now, src_ok, wrapped;
  int old_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_uf = 0; m_mode = 0; m_psc = 0; m_pact = 0; m_ph = 0;
      m_arr = 65535; m_cnt = 0; m_ien = 0; q1 = 0; q2 = 0; q3 = 0;
      m_cf = 0; m_of = 0; m_capen = 0; m_ma = 0; m_mb = 0;
      for (int c = 0; c < 4; c++) m_cap[c] = 0;
    end else begin
      ug_now = bus_wr && bus_addr == 0 && bus_wdata[1];
      rr = q2 & ~q3;
      ff = ~q2 & q3;
      src_ok = (m_mode == 0) ? tick : (m_mode == 1) ? rr[4] : 1'b0;
      old_cnt = m_cnt;
      wrapped = 0;
      for (int c = 0; c < 4; c++)
        hits[c] = m_run && m_capen[4*c] &&
                  ((rr[c] && (!m_capen[4*c+1] || m_capen[4*c+3])) || (ff[c] && m_capen[4*c+1]));
      if (ug_now) begin
        m_cnt = 0; m_ph = 0; m_pact = m_psc;
      end else if (m_run && src_ok) begin
        if (m_ph == m_pact) begin
          m_ph = 0;
          if (m_cnt == m_arr) begin m_cnt = 0; wrapped = 1; m_pact = m_psc; end
          else m_cnt = (m_cnt + 1) % 65536;
        end else m_ph++;
      end
      if (bus_wr && bus_addr == 1) begin
        m_uf &= bus_wdata[0]; m_cf &= bus_wdata[4:1]; m_of &= bus_wdata[8:5];
      end
      m_of |= hits & m_cf;
      m_cf |= hits;
      m_uf |= wrapped;
      for (int c = 0; c < 4; c++) if (hits[c]) m_cap[c] = old_cnt;
      if (bus_wr)
        case (bus_addr)
          0: begin m_run = bus_wdata[0]; m_mode = int'(bus_wdata[3:2]); end
          2: m_ien = bus_wdata[4:0];
          3: m_psc = int'(bus_wdata);
          4: m_arr = int'(bus_wdata);
          6: m_capen = bus_wdata;
          7: m_ma = bus_wdata;
          8: m_mb = bus_wdata;
          default: ;
        endcase
      q3 = q2; q2 = q1; q1 = {ext_clk, cap_in};
    end
  end

  function automatic bit [15:0] model_read(input int a);
    case (a)
      0: return {12'b0, 2'(m_mode), 1'b0, m_run};
      1: return {7'b0, m_of, m_cf, m_uf};
      2: return {11'b0, m_ien};
      3: return 16'(m_psc);
      4: return 16'(m_arr);
      5: return 16'(m_cnt);
      6: return m_capen;
      7: return m_ma;
      8: return m_mb;
      9, 10, 11, 12: return 16'(m_cap[a-9]);
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n) chk("R10", "irq", {15'b0, irq}, {15'b0, |({m_cf, m_uf} & m_ien)});

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk); bus_addr = 4'(a);
    #1 chk(tag, $sformatf("reg %0d", a), bus_rdata, model_read(a));
  endtask

  task automatic rdx(input int a, input logic [15:0] exp, input string tag);
    @(negedge clk); bus_addr = 4'(a);
    #1 chk(tag, $sformatf("reg %0d", a), bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1;
    // R12 reset state
    rdx(5, 16'h0000, "R12"); rdx(4, 16'hffff, "R12"); rdx(1, 16'h0000, "R12");
    rdx(0, 16'h0000, "R12"); rdx(3, 16'h0000, "R12");
    chk("R12", "irq", {15'b0, irq}, 16'h0);
    // R2 wrap at reload, update flag
    wr(4, 16'd5); tick = 1'b1; wr(0, 16'h0001);
    idle(3); rd(5, "R2"); idle(4); rd(5, "R2"); rd(1, "R2");
    wr(2, 16'h0001); idle(2); wr(1, 16'hfffe); rd(1, "R2");
    // R1 prescaler with gapped ticks, R3 update generation
    wr(3, 16'd2); wr(0, 16'h0003);
    rdx(0, 16'h0001, "R3");
    for (int i = 0; i < 12; i++) begin tick = (i % 3 != 0); rd(5, "R1"); end
    tick = 1'b1;
    wr(2, 16'h0000); wr(1, 16'h0000); wr(0, 16'h0003); rd(1, "R3"); rd(5, "R3");
    // R4 stopped counter, no capture
    wr(0, 16'h0000); wr(6, 16'h0001); rd(5, "R4");
    cap_in[0] = 1'b1; idle(5); rd(5, "R4"); rd(1, "R4"); rd(9, "R4");
    cap_in = 4'h0; idle(5);
    // R6 / R7 edge selection and capture values
    wr(1, 16'h0000); wr(4, 16'd100); wr(3, 16'd0); wr(6, 16'h9b31); wr(0, 16'h0001);
    idle(2); cap_in = 4'hf; idle(5);
    rdx(1, 16'h001a, "R6");
    for (int a = 9; a < 13; a++) rd(a, "R7");
    wr(1, 16'h0000); cap_in = 4'h0; idle(5);
    rd(1, "R6");
    for (int a = 9; a < 13; a++) rd(a, "R7");
    wr(6, 16'h0000); wr(1, 16'h0000); cap_in = 4'hf; idle(5);
    rdx(1, 16'h0000, "R6");
    cap_in = 4'h0; idle(5);
    // R8 overcapture
    wr(6, 16'h0001); wr(1, 16'h0000);
    cap_in[0] = 1'b1; idle(5); cap_in[0] = 1'b0; idle(5); cap_in[0] = 1'b1; idle(5);
    rdx(1, 16'h0022, "R8"); rd(9, "R8");
    // R9 write-zero-to-clear
    wr(1, 16'hffff); rdx(1, 16'h0022, "R9");
    wr(1, 16'hffdf); rdx(1, 16'h0002, "R9");
    // R10 interrupt gating, overcapture alone does not interrupt
    wr(2, 16'h001f); idle(2); chk("R10", "irq with capture flag", {15'b0, irq}, 16'h1);
    cap_in[0] = 1'b0; idle(5); cap_in[0] = 1'b1; idle(5);
    wr(0, 16'h0000); wr(1, 16'hfffc);
    rdx(1, 16'h0020, "R10"); idle(1);
    chk("R10", "irq with only overcapture", {15'b0, irq}, 16'h0);
    // R5 count sources
    wr(0, 16'h0007);
    for (int i = 0; i < 5; i++) begin ext_clk = 1'b1; idle(3); ext_clk = 1'b0; idle(3); end
    idle(3); rdx(5, 16'd5, "R5");
    wr(0, 16'h0009);
    for (int i = 0; i < 3; i++) begin ext_clk = 1'b1; idle(3); ext_clk = 1'b0; idle(3); end
    rdx(5, 16'd5, "R5");
    // R11 mode registers
    wr(7, 16'ha55a); wr(8, 16'h1234);
    rdx(7, 16'ha55a, "R11"); rdx(8, 16'h1234, "R11");
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule